// File: doc/BRIEF.md
# Partitioned SAT Decision Controller

This block is the sequencing engine of a satisfiability search that runs on a fixed-size window of the problem, called a bin, at a time. A bin holds a bounded set of clauses over a bounded set of variables. The controller loads a bin through a request/acknowledge handshake with an external bin loader. It then broadcasts variable assignments to an external clause array and waits for that array to report that implications have settled. When the array flags a conflict, the controller hands over to an external conflict analyser. It acts on the backtrack target that the analyser returns.

Variables inside a bin are decided in increasing index order, and the index is a static tag chosen ahead of time. Decisions made in earlier bins are kept in an outside store. When a bin that has such stored decisions is loaded, the controller re-broadcasts them in ascending decision-level order before it makes any new decision. A bin that becomes fully satisfied ends in a local SAT result, and the controller moves on to the next bin. When the last bin is satisfied, the whole problem is SAT. A backtrack that targets a different bin leaves through a local UNSAT result, and the controller reloads that bin. A conflict that cannot be backtracked any further ends the search as UNSAT.

Top module: `dc_decision_ctrl`

## Requirements
- R1: After synchronous reset the controller requests bin index 0 (load_req high, load_bin 0), with no assignment broadcast and all four result outputs low.
- R2: When load_ack arrives, cur_bin takes the requested index and all per-bin bookkeeping is cleared (assigned, replayed and backtrack flags).
- R3: New decisions are broadcast with asg_replay low and value 0, in increasing variable index. A variable is skipped if it is unused in the bin (bin_used bit 0), if all of its clauses are satisfied (cls_var_sat bit 1), if it is implied (cls_var_implied bit 1), or if it is already assigned. Each decision follows the cls_impl_done of the previous one.
- R4: Stored decisions (bin_decided bit 1) are broadcast first, with asg_replay high and their stored bin_value bit. They go out in ascending bin_level order, with ties going to the lower index, one per cls_impl_done.
- R5: With cls_all_sat high, or with no eligible variable left in the assign state, part_sat pulses for one cycle. In a bin that is not the last, a load of cur_bin+1 is then requested.
- R6: If part_sat occurs in bin NUM_BINS-1, glob_sat is raised and held, and no further load is requested.
- R7: While load_ack is low, load_req stays high and load_bin stays stable.
- R8: cls_impl_done with cls_conflict pulses ana_start. If the analyser returns a target in the current bin, undo_valid pulses with undo_from equal to the target index. That variable is then decided again with the inverted value, and the later variables restart from value 0.
- R9: If the analyser target bin differs from cur_bin, part_unsat pulses for one cycle, followed by a load request for the target bin.
- R10: If the analyser reports ana_none, glob_unsat is raised and held, with no further assignment or load request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_req | output | 1 | Bin load request |
| load_bin | output | BIN_W | Index of the bin requested |
| load_ack | input | 1 | Loader has placed the bin (one-cycle pulse) |
| bin_used | input | NUM_VARS | Variable occurs in the loaded bin |
| bin_decided | input | NUM_VARS | Variable carries a stored decision |
| bin_value | input | NUM_VARS | Stored decision value per variable |
| bin_level | input | NUM_VARS*LVL_W | Stored decision level per variable, packed |
| cls_all_sat | input | 1 | Every clause of the bin is satisfied |
| cls_var_sat | input | NUM_VARS | All clauses holding the variable are satisfied |
| cls_var_implied | input | NUM_VARS | Variable was implied by the clause array |
| cls_impl_done | input | 1 | Implications have settled |
| cls_conflict | input | 1 | Conflict present (valid with cls_impl_done) |
| asg_valid | output | 1 | Assignment broadcast strobe |
| asg_var | output | IDX_W | Variable index being assigned |
| asg_value | output | 1 | Assigned value |
| asg_replay | output | 1 | Broadcast is a replay of a stored decision |
| undo_valid | output | 1 | Retract assignments strobe |
| undo_from | output | IDX_W | Lowest index retracted |
| ana_start | output | 1 | Conflict analysis start strobe |
| ana_valid | input | 1 | Analyser result valid |
| ana_none | input | 1 | No backtrack possible |
| ana_bin | input | BIN_W | Bin holding the backtrack variable |
| ana_var | input | IDX_W | Index of the backtrack variable |
| cur_bin | output | BIN_W | Bin currently loaded |
| part_sat | output | 1 | Current bin satisfied |
| part_unsat | output | 1 | Backtrack leaves the current bin |
| glob_sat | output | 1 | Problem satisfiable |
| glob_unsat | output | 1 | Problem unsatisfiable |

## Verification
The hardest situation to reach from the ports is the replay of stored decisions in the right order. It only happens after a bin change, so the bench first takes bin 0 through a satisfied pass and only then loads bin 1. On bin 1 it presents every combination of four levels in the range 0 to 3, which covers every permutation and every tie. The in-bin backtrack and the cross-bin backtrack are reached by playing the clause array and the analyser by hand. The bench raises a conflict on a chosen decision and returns a target inside or outside the current bin.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [3:0] {
        ST_REFRESH,
        ST_ASSIGN,
        ST_WAIT,
        ST_ANALYZE,
        ST_EXEC,
        ST_PSAT,
        ST_PUNSAT,
        ST_GSAT,
        ST_GUNSAT
    } dc_state_e;

    // Commands to the per-bin variable bookkeeping.
    typedef struct packed {
        logic clear_all;
        logic mark;
        logic mark_replay;
        logic undo;
        logic stop_replay;
    } trk_op_t;

    function automatic logic is_final(dc_state_e s);
        return (s == ST_GSAT) || (s == ST_GUNSAT);
    endfunction

endpackage

// File: rtl/dc_var_track.sv
module dc_var_track
    import dc_pkg::*;
#(
    parameter int NUM_VARS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  trk_op_t             op,
    input  logic [IDX_W-1:0]    op_idx,
    input  logic                op_val,
    output logic [NUM_VARS-1:0] assigned,
    output logic [NUM_VARS-1:0] values,
    output logic [NUM_VARS-1:0] replayed
);

    logic [NUM_VARS-1:0] asg_n, val_n, rep_n;

    always_comb begin
        asg_n = assigned;
        val_n = values;
        rep_n = replayed;
        if (op.clear_all) begin
            asg_n = '0;
            val_n = '0;
            rep_n = '0;
        end else begin
            if (op.undo) begin
                for (int i = 0; i < NUM_VARS; i++) begin
                    if (i >= int'(op_idx)) asg_n[i] = 1'b0;
                end
            end
            if (op.stop_replay) rep_n = '1;
            if (op.mark) begin
                asg_n[op_idx] = 1'b1;
                val_n[op_idx] = op_val;
                if (op.mark_replay) rep_n[op_idx] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            assigned <= '0;
            values   <= '0;
            replayed <= '0;
        end else begin
            assigned <= asg_n;
            values   <= val_n;
            replayed <= rep_n;
        end
    end

    // R8: a retraction frees the backtrack variable itself
    p_undo_frees_r8: assert property (@(posedge clk) disable iff (rst)
        (op.undo && !op.mark && !op.clear_all) |=> !assigned[$past(op_idx)]);

endmodule

// File: rtl/dc_first_free.sv
module dc_first_free #(
    parameter int NUM_VARS = 8,
    parameter int IDX_W    = 3
) (
    input  logic [NUM_VARS-1:0] cand,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_VARS - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dc_min_level_pick.sv
module dc_min_level_pick #(
    parameter int NUM_VARS = 8,
    parameter int IDX_W    = 3,
    parameter int LVL_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_VARS-1:0]       pend,
    input  logic [NUM_VARS*LVL_W-1:0] levels,
    output logic                      found,
    output logic [IDX_W-1:0]          idx
);

    logic [LVL_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NUM_VARS; i++) begin
            if (pend[i] && (!found || (levels[i*LVL_W +: LVL_W] < best))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = levels[i*LVL_W +: LVL_W];
            end
        end
    end

    // Independent scan: does any pending entry beat the chosen one?
    logic beaten;
    always_comb begin
        beaten = 1'b0;
        for (int j = 0; j < NUM_VARS; j++) begin
            if (found && pend[j] &&
                (levels[j*LVL_W +: LVL_W] < levels[int'(idx)*LVL_W +: LVL_W]))
                beaten = 1'b1;
        end
    end

    // R4: replay always takes the lowest pending level
    p_lowest_level_r4: assert property (@(posedge clk) disable iff (rst) !beaten);

endmodule

// File: rtl/dc_decision_ctrl.sv
module dc_decision_ctrl
    import dc_pkg::*;
#(
    parameter int NUM_VARS = 8,
    parameter int NUM_BINS = 8,
    parameter int LVL_W    = 8,
    localparam int IDX_W   = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1,
    localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    output logic                      load_req,
    output logic [BIN_W-1:0]          load_bin,
    input  logic                      load_ack,
    input  logic [NUM_VARS-1:0]       bin_used,
    input  logic [NUM_VARS-1:0]       bin_decided,
    input  logic [NUM_VARS-1:0]       bin_value,
    input  logic [NUM_VARS*LVL_W-1:0] bin_level,
    input  logic                      cls_all_sat,
    input  logic [NUM_VARS-1:0]       cls_var_sat,
    input  logic [NUM_VARS-1:0]       cls_var_implied,
    input  logic                      cls_impl_done,
    input  logic                      cls_conflict,
    output logic                      asg_valid,
    output logic [IDX_W-1:0]          asg_var,
    output logic                      asg_value,
    output logic                      asg_replay,
    output logic                      undo_valid,
    output logic [IDX_W-1:0]          undo_from,
    output logic                      ana_start,
    input  logic                      ana_valid,
    input  logic                      ana_none,
    input  logic [BIN_W-1:0]          ana_bin,
    input  logic [IDX_W-1:0]          ana_var,
    output logic [BIN_W-1:0]          cur_bin,
    output logic                      part_sat,
    output logic                      part_unsat,
    output logic                      glob_sat,
    output logic                      glob_unsat
);

    localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(NUM_BINS - 1);

    dc_state_e          state, state_n;
    logic               loaded, loaded_n;
    logic [BIN_W-1:0]   target, target_n, cur_n;
    logic [IDX_W-1:0]   bt_idx, bt_n;
    logic               flip_v, flip_v_n;
    logic [IDX_W-1:0]   flip_idx, flip_idx_n;

    logic               asg_v_n, asg_val_n, asg_rep_n, undo_v_n, ana_start_n;
    logic [IDX_W-1:0]   asg_idx_n, undo_idx_n;

    trk_op_t            op;
    logic [IDX_W-1:0]   op_idx;
    logic               op_val;

    logic [NUM_VARS-1:0] assigned, values, replayed;
    logic [NUM_VARS-1:0] rep_pend, free_cand;
    logic                rep_found, free_found;
    logic [IDX_W-1:0]    rep_idx, free_idx;
    logic                do_replay, do_assign, new_val;

    dc_var_track #(.NUM_VARS(NUM_VARS), .IDX_W(IDX_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .op_idx   (op_idx),
        .op_val   (op_val),
        .assigned (assigned),
        .values   (values),
        .replayed (replayed)
    );

    assign rep_pend  = bin_decided & ~replayed;
    assign free_cand = bin_used & ~cls_var_sat & ~cls_var_implied & ~assigned;

    dc_min_level_pick #(.NUM_VARS(NUM_VARS), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_replay_pick (
        .clk    (clk),
        .rst    (rst),
        .pend   (rep_pend),
        .levels (bin_level),
        .found  (rep_found),
        .idx    (rep_idx)
    );

    dc_first_free #(.NUM_VARS(NUM_VARS), .IDX_W(IDX_W)) u_next_free (
        .cand  (free_cand),
        .found (free_found),
        .idx   (free_idx)
    );

    assign new_val = (flip_v && (flip_idx == free_idx)) ? ~values[free_idx] : 1'b0;

    always_comb begin
        state_n     = state;
        loaded_n    = loaded;
        target_n    = target;
        cur_n       = cur_bin;
        bt_n        = bt_idx;
        flip_v_n    = flip_v;
        flip_idx_n  = flip_idx;
        asg_v_n     = 1'b0;
        asg_idx_n   = asg_var;
        asg_val_n   = asg_value;
        asg_rep_n   = asg_replay;
        undo_v_n    = 1'b0;
        undo_idx_n  = undo_from;
        ana_start_n = 1'b0;
        op          = '0;
        op_idx      = '0;
        op_val      = 1'b0;
        do_replay   = 1'b0;
        do_assign   = 1'b0;

        unique case (state)
            ST_REFRESH: begin
                if (!loaded) begin
                    if (load_ack) begin
                        loaded_n     = 1'b1;
                        cur_n        = target;
                        op.clear_all = 1'b1;
                        flip_v_n     = 1'b0;
                    end
                end else begin
                    loaded_n = 1'b0;
                    if (rep_found) begin
                        do_replay = 1'b1;
                        state_n   = ST_WAIT;
                    end else begin
                        state_n = ST_ASSIGN;
                    end
                end
            end
            ST_ASSIGN: begin
                if (cls_all_sat || !free_found) begin
                    state_n = ST_PSAT;
                end else begin
                    do_assign = 1'b1;
                    state_n   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cls_impl_done) begin
                    if (cls_conflict) begin
                        ana_start_n = 1'b1;
                        state_n     = ST_ANALYZE;
                    end else if (rep_found) begin
                        do_replay = 1'b1;
                    end else begin
                        state_n = ST_ASSIGN;
                    end
                end
            end
            ST_ANALYZE: begin
                if (ana_valid) begin
                    if (ana_none) begin
                        state_n = ST_GUNSAT;
                    end else if (ana_bin != cur_bin) begin
                        target_n = ana_bin;
                        state_n  = ST_PUNSAT;
                    end else begin
                        bt_n    = ana_var;
                        state_n = ST_EXEC;
                    end
                end
            end
            ST_EXEC: begin
                undo_v_n       = 1'b1;
                undo_idx_n     = bt_idx;
                op.undo        = 1'b1;
                op.stop_replay = 1'b1;
                op_idx         = bt_idx;
                flip_v_n       = 1'b1;
                flip_idx_n     = bt_idx;
                state_n        = ST_ASSIGN;
            end
            ST_PSAT: begin
                if (cur_bin == LAST_BIN) begin
                    state_n = ST_GSAT;
                end else begin
                    target_n = cur_bin + BIN_W'(1);
                    state_n  = ST_REFRESH;
                end
            end
            ST_PUNSAT: state_n = ST_REFRESH;
            ST_GSAT:   state_n = ST_GSAT;
            ST_GUNSAT: state_n = ST_GUNSAT;
            default:   state_n = ST_REFRESH;
        endcase

        if (do_replay) begin
            asg_v_n        = 1'b1;
            asg_idx_n      = rep_idx;
            asg_val_n      = bin_value[rep_idx];
            asg_rep_n      = 1'b1;
            op.mark        = 1'b1;
            op.mark_replay = 1'b1;
            op_idx         = rep_idx;
            op_val         = bin_value[rep_idx];
        end
        if (do_assign) begin
            asg_v_n   = 1'b1;
            asg_idx_n = free_idx;
            asg_val_n = new_val;
            asg_rep_n = 1'b0;
            op.mark   = 1'b1;
            op_idx    = free_idx;
            op_val    = new_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_REFRESH;
            loaded     <= 1'b0;
            target     <= '0;
            cur_bin    <= '0;
            bt_idx     <= '0;
            flip_v     <= 1'b0;
            flip_idx   <= '0;
            asg_valid  <= 1'b0;
            asg_var    <= '0;
            asg_value  <= 1'b0;
            asg_replay <= 1'b0;
            undo_valid <= 1'b0;
            undo_from  <= '0;
            ana_start  <= 1'b0;
        end else begin
            state      <= state_n;
            loaded     <= loaded_n;
            target     <= target_n;
            cur_bin    <= cur_n;
            bt_idx     <= bt_n;
            flip_v     <= flip_v_n;
            flip_idx   <= flip_idx_n;
            asg_valid  <= asg_v_n;
            asg_var    <= asg_idx_n;
            asg_value  <= asg_val_n;
            asg_replay <= asg_rep_n;
            undo_valid <= undo_v_n;
            undo_from  <= undo_idx_n;
            ana_start  <= ana_start_n;
        end
    end

    assign load_req   = (state == ST_REFRESH) && !loaded;
    assign load_bin   = target;
    assign part_sat   = (state == ST_PSAT);
    assign part_unsat = (state == ST_PUNSAT);
    assign glob_sat   = (state == ST_GSAT);
    assign glob_unsat = (state == ST_GUNSAT);

    // R7: request held with a stable index until acknowledged
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (load_req && !load_ack) |=> (load_req && $stable(load_bin)));

    // R5: a satisfied non-final bin is followed by a request for the next one
    p_next_bin_r5: assert property (@(posedge clk) disable iff (rst)
        (part_sat && (cur_bin != LAST_BIN)) |=>
        (load_req && (load_bin == $past(cur_bin) + BIN_W'(1))));

    // R6: global SAT is terminal and requests nothing
    p_gsat_hold_r6: assert property (@(posedge clk) disable iff (rst)
        glob_sat |=> (glob_sat && !load_req));

    // R10: global UNSAT is terminal and broadcasts nothing
    p_gunsat_hold_r10: assert property (@(posedge clk) disable iff (rst)
        glob_unsat |=> (glob_unsat && !asg_valid && !load_req));

    // R9: leaving for another bin requests a bin other than the current one
    p_punsat_target_r9: assert property (@(posedge clk) disable iff (rst)
        part_unsat |=> (load_req && (load_bin != cur_bin)));

    // R1: no final result while a bin is still being requested
    p_no_result_loading_r1: assert property (@(posedge clk) disable iff (rst)
        load_req |-> !(glob_sat || glob_unsat || asg_valid));

endmodule

// File: tb/dc_decision_ctrl_bench.sv
module dc_decision_ctrl_bench;

    localparam int NV = 4;
    localparam int NB = 3;
    localparam int LW = 4;
    localparam int BW = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic load_req, load_ack;
    logic [BW-1:0] load_bin, ana_bin, cur_bin;
    logic [NV-1:0] bin_used, bin_decided, bin_value, cls_var_sat, cls_var_implied;
    logic [NV*LW-1:0] bin_level;
    logic cls_all_sat, cls_impl_done, cls_conflict;
    logic asg_valid, asg_value, asg_replay, undo_valid, ana_start;
    logic [IW-1:0] asg_var, undo_from, ana_var;
    logic ana_valid, ana_none;
    logic part_sat, part_unsat, glob_sat, glob_unsat;

    dc_decision_ctrl #(.NUM_VARS(NV), .NUM_BINS(NB), .LVL_W(LW)) u_dc_decision_ctrl (
        .clk(clk), .rst(rst),
        .load_req(load_req), .load_bin(load_bin), .load_ack(load_ack),
        .bin_used(bin_used), .bin_decided(bin_decided), .bin_value(bin_value),
        .bin_level(bin_level),
        .cls_all_sat(cls_all_sat), .cls_var_sat(cls_var_sat),
        .cls_var_implied(cls_var_implied), .cls_impl_done(cls_impl_done),
        .cls_conflict(cls_conflict),
        .asg_valid(asg_valid), .asg_var(asg_var), .asg_value(asg_value),
        .asg_replay(asg_replay), .undo_valid(undo_valid), .undo_from(undo_from),
        .ana_start(ana_start), .ana_valid(ana_valid), .ana_none(ana_none),
        .ana_bin(ana_bin), .ana_var(ana_var), .cur_bin(cur_bin),
        .part_sat(part_sat), .part_unsat(part_unsat),
        .glob_sat(glob_sat), .glob_unsat(glob_unsat)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        load_ack = 1'b0; cls_impl_done = 1'b0; cls_conflict = 1'b0;
        cls_all_sat = 1'b0; cls_var_sat = '0; cls_var_implied = '0;
        bin_used = '0; bin_decided = '0; bin_value = '0; bin_level = '0;
        ana_valid = 1'b0; ana_none = 1'b0; ana_bin = '0; ana_var = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Wait for a load request, check its index, then acknowledge with bin data.
    task automatic load(input int exp_bin, input string req, input logic [NV-1:0] used,
                        input logic [NV-1:0] dec, input logic [NV-1:0] val,
                        input logic [NV*LW-1:0] lvl, input logic [NV-1:0] sat,
                        input logic [NV-1:0] imp, input logic allsat);
        for (int i = 0; i < 12 && !load_req; i++) @(negedge clk);
        chk(load_req && (int'(load_bin) == exp_bin), req, int'(load_bin), exp_bin);
        bin_used = used; bin_decided = dec; bin_value = val; bin_level = lvl;
        cls_var_sat = sat; cls_var_implied = imp; cls_all_sat = allsat;
        load_ack = 1'b1;
        @(negedge clk);
        load_ack = 1'b0;
    endtask

    task automatic expect_asg(input int v, input int val, input bit rep, input string req);
        for (int i = 0; i < 12 && !asg_valid; i++) @(negedge clk);
        chk(asg_valid && int'(asg_var) == v && int'(asg_value) == val && asg_replay == rep,
            req, asg_valid ? int'(asg_var) * 10 + int'(asg_value) : -1, v * 10 + val);
    endtask

    task automatic pulse_impl(input bit conflict);
        cls_impl_done = 1'b1;
        cls_conflict  = conflict;
        @(negedge clk);
        cls_impl_done = 1'b0;
        cls_conflict  = 1'b0;
    endtask

    // sel: 0 part_sat, 1 part_unsat, 2 glob_sat, 3 glob_unsat, 4 ana_start, 5 undo_valid
    function automatic bit sig(input int sel);
        case (sel)
            0: return part_sat;
            1: return part_unsat;
            2: return glob_sat;
            3: return glob_unsat;
            4: return ana_start;
            default: return undo_valid;
        endcase
    endfunction

    task automatic wait_sig(input int sel, input string req);
        int stray = 0;
        for (int i = 0; i < 12 && !sig(sel); i++) begin
            if (asg_valid) stray++;
            @(negedge clk);
        end
        chk(sig(sel) && stray == 0, req, stray, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [NV*LW-1:0] lv;
        int lvl_of [NV];

        // R1 and R7: reset state, request held without acknowledge
        do_reset();
        chk(load_req && load_bin == 0 && !asg_valid && !part_sat && !part_unsat &&
            !glob_sat && !glob_unsat, "R1", int'(load_req), 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(load_req && load_bin == 0, "R7", int'(load_bin), 0);
        end

        // R3 and R5: sweep used and satisfied masks over bin 0
        for (int u = 0; u < 16; u++) begin
            for (int s = 0; s < 16; s++) begin
                do_reset();
                load(0, "R1", NV'(u), '0, '0, '0, NV'(s), '0, 1'b0);
                for (int v = 0; v < NV; v++) begin
                    if (u[v] && !s[v]) begin
                        expect_asg(v, 0, 1'b0, "R3");
                        pulse_impl(1'b0);
                    end
                end
                wait_sig(0, "R5");
                @(negedge clk);
                chk(load_req && load_bin == 1, "R5", int'(load_bin), 1);
            end
        end

        // R3: implied variables are skipped
        do_reset();
        load(0, "R1", 4'b1111, '0, '0, '0, '0, 4'b0101, 1'b0);
        expect_asg(1, 0, 1'b0, "R3"); pulse_impl(1'b0);
        expect_asg(3, 0, 1'b0, "R3"); pulse_impl(1'b0);
        wait_sig(0, "R5");

        // R4 and R2: replay order over every level combination on bin 1
        for (int a = 0; a < 4; a++) for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) for (int d = 0; d < 4; d++) begin
            lvl_of[0] = a; lvl_of[1] = b; lvl_of[2] = c; lvl_of[3] = d;
            lv = {LW'(d), LW'(c), LW'(b), LW'(a)};
            do_reset();
            load(0, "R1", 4'b1111, '0, '0, '0, '0, '0, 1'b1);
            wait_sig(0, "R5");
            load(1, "R5", 4'b1111, 4'b1111, 4'b0110, lv, '0, '0, 1'b0);
            chk(cur_bin == 1, "R2", int'(cur_bin), 1);
            for (int l = 0; l < 4; l++) for (int v = 0; v < NV; v++) begin
                if (lvl_of[v] == l) begin
                    expect_asg(v, (4'b0110 >> v) & 1, 1'b1, "R4");
                    pulse_impl(1'b0);
                end
            end
            wait_sig(0, "R5");
            @(negedge clk);
            chk(load_req && load_bin == 2, "R5", int'(load_bin), 2);
        end

        // R4: partial replay then fresh decisions
        do_reset();
        load(0, "R1", 4'b1111, '0, '0, '0, '0, '0, 1'b1);
        wait_sig(0, "R5");
        load(1, "R5", 4'b1111, 4'b0101, 4'b0001, {4'd0, 4'd1, 4'd0, 4'd3}, '0, '0, 1'b0);
        expect_asg(2, 0, 1'b1, "R4"); pulse_impl(1'b0);
        expect_asg(0, 1, 1'b1, "R4"); pulse_impl(1'b0);
        expect_asg(1, 0, 1'b0, "R3"); pulse_impl(1'b0);
        expect_asg(3, 0, 1'b0, "R3"); pulse_impl(1'b0);
        wait_sig(0, "R5");

        // R6: last bin satisfied
        do_reset();
        load(0, "R1", 4'b1111, '0, '0, '0, '0, '0, 1'b1);
        wait_sig(0, "R5");
        load(1, "R5", 4'b1111, '0, '0, '0, '0, '0, 1'b1);
        wait_sig(0, "R5");
        load(2, "R5", 4'b1111, '0, '0, '0, '0, '0, 1'b1);
        wait_sig(2, "R6");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(glob_sat && !load_req, "R6", int'(glob_sat), 1);
        end

        // R8: backtrack within the current bin
        do_reset();
        load(0, "R1", 4'b1111, '0, '0, '0, '0, '0, 1'b0);
        expect_asg(0, 0, 1'b0, "R3"); pulse_impl(1'b0);
        expect_asg(1, 0, 1'b0, "R3"); pulse_impl(1'b1);
        wait_sig(4, "R8");
        ana_valid = 1'b1; ana_none = 1'b0; ana_bin = 2'd0; ana_var = 2'd1;
        @(negedge clk);
        ana_valid = 1'b0;
        wait_sig(5, "R8");
        chk(undo_from == 1, "R8", int'(undo_from), 1);
        expect_asg(1, 1, 1'b0, "R8"); pulse_impl(1'b0);
        expect_asg(2, 0, 1'b0, "R8"); pulse_impl(1'b0);
        expect_asg(3, 0, 1'b0, "R8"); pulse_impl(1'b0);
        wait_sig(0, "R5");

        // R9: backtrack into an earlier bin
        do_reset();
        load(0, "R1", 4'b1111, '0, '0, '0, '0, '0, 1'b1);
        wait_sig(0, "R5");
        load(1, "R5", 4'b1111, '0, '0, '0, '0, '0, 1'b0);
        expect_asg(0, 0, 1'b0, "R3"); pulse_impl(1'b1);
        wait_sig(4, "R8");
        ana_valid = 1'b1; ana_none = 1'b0; ana_bin = 2'd0; ana_var = 2'd2;
        @(negedge clk);
        ana_valid = 1'b0;
        wait_sig(1, "R9");
        @(negedge clk);
        chk(load_req && load_bin == 0, "R9", int'(load_bin), 0);

        // R10: no backtrack possible
        do_reset();
        load(0, "R1", 4'b1111, '0, '0, '0, '0, '0, 1'b0);
        expect_asg(0, 0, 1'b0, "R3"); pulse_impl(1'b1);
        wait_sig(4, "R8");
        ana_valid = 1'b1; ana_none = 1'b1;
        @(negedge clk);
        ana_valid = 1'b0; ana_none = 1'b0;
        wait_sig(3, "R10");
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(glob_unsat && !load_req && !asg_valid, "R10", int'(glob_unsat), 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule